// File: doc/BRIEF.md
# Always-Full FIFO with In-Place Value Substitution

This block is a register-based queue that never runs empty or partial. Each insert strobe writes one new word and, in the same operation, removes the oldest stored word, so the queue always holds exactly DEPTH words. The removed word appears on a registered output after the strobe's clock edge.

An insert may also carry a substitution request: a match value, a replacement value and an enable. When the enable is high during an insert, every stored word equal to the match value is rewritten to the replacement value on that clock edge. All words are compared in parallel. This means substitutions issued on successive inserts stack in order: if 5 becomes 6 and then 6 becomes 7, a word that started as 5 leaves the queue as 7.

The data stays in place. A single pointer marks both the oldest word and the slot that receives the new word, and it wraps from DEPTH-1 back to 0. Storage is one register per word, each with its own comparator and replace multiplexer, so the logic cost grows with depth while every substitution completes in one cycle.

Top module: `subst_fifo`

## Requirements
- R1: After reset, `pop_data` reads FILL. Every slot holds FILL, so the first DEPTH inserts return FILL.
- R2: On a cycle with `push` high, `pop_data` takes the oldest stored word at that clock edge. Words leave in the order they were inserted, each one DEPTH inserts after its own insert.
- R3: While `push` is low, `pop_data` and the stored contents do not change, whatever `push_data` holds.
- R4: On a cycle with `push` and `chg_en` both high, every stored word other than the one being removed that equals `cmp_value` becomes `chg_value` at that edge.
- R5: The word removed on a cycle is the value it held before that cycle's substitution.
- R6: The inserted word is stored exactly as given, even when it equals `cmp_value`.
- R7: Substitutions on successive inserts compose in order. After a 5→6 substitution and then a 6→7 substitution, a word first inserted as 5 is read out as 7.
- R8: An insert with `chg_en` low modifies no stored word.
- R9: `chg_en` high with `push` low has no effect on contents or output.
- R10: The slot pointer advances by one on each insert and wraps from DEPTH-1 to 0, so order holds across any number of inserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Insert strobe; also removes the oldest word |
| push_data | input | WIDTH | Word to insert |
| cmp_value | input | WIDTH | Match value for substitution |
| chg_value | input | WIDTH | Replacement value for substitution |
| chg_en | input | 1 | Applies the substitution on this insert |
| pop_data | output | WIDTH | Registered word removed by the last insert |

## Verification
`pop_data` is registered. It changes at the rising edge where `push` is sampled high, so the bench drives inputs on the falling edge and compares the output at the next falling edge, one cycle after the strobe. A substitution takes effect at that same edge, but it only becomes visible when an affected word is removed, which happens some number of inserts later, at most DEPTH. For that reason the bench keeps a reference model of every slot and applies each substitution to it immediately. Every later removal then checks the accumulated effect. Idle periods are checked by holding the strobe low for several cycles and then confirming that both the output and the next DEPTH removals are unchanged.

// File: rtl/subst_pkg.sv
package subst_pkg;
  localparam int unsigned DEF_WIDTH = 8;
  localparam int unsigned DEF_DEPTH = 512;
  localparam logic [DEF_WIDTH-1:0] DEF_FILL = '0;
endpackage

// File: rtl/subst_ptr.sv
module subst_ptr #(
  parameter int unsigned DEPTH = subst_pkg::DEF_DEPTH,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R10
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr == LAST) |=> (ptr == '0));
  // R10
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr));
endmodule

// File: rtl/subst_cell.sv
module subst_cell #(
  parameter int unsigned WIDTH = subst_pkg::DEF_WIDTH,
  parameter logic [WIDTH-1:0] FILL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             sel,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] cmp,
  input  logic [WIDTH-1:0] chg,
  input  logic             en,
  output logic [WIDTH-1:0] q
);
  logic hit;
  assign hit = en && (q == cmp);

  always_ff @(posedge clk) begin
    if (rst) q <= FILL;
    else if (push) begin
      if (sel) q <= din;
      else if (hit) q <= chg;
    end
  end

  // R4
  cell_replace_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !sel && en && q == cmp) |=> (q == $past(chg)));
  // R6
  cell_load_chk: assert property (@(posedge clk) disable iff (rst)
    (push && sel) |=> (q == $past(din)));
  // R8
  cell_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !sel && !en) |=> $stable(q));
  // R3
  cell_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !push |=> $stable(q));
endmodule

// File: rtl/subst_fifo.sv
module subst_fifo #(
  parameter int unsigned WIDTH = subst_pkg::DEF_WIDTH,
  parameter int unsigned DEPTH = subst_pkg::DEF_DEPTH,
  parameter logic [WIDTH-1:0] FILL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic [WIDTH-1:0] cmp_value,
  input  logic [WIDTH-1:0] chg_value,
  input  logic             chg_en,
  output logic [WIDTH-1:0] pop_data
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [PW-1:0]    slot;
  logic [DEPTH-1:0] sel;
  logic [WIDTH-1:0] word_q [DEPTH];
  logic [WIDTH-1:0] pop_q;

  subst_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .adv(push), .ptr(slot)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign sel[i] = (slot == PW'(i));
    subst_cell #(.WIDTH(WIDTH), .FILL(FILL)) u_cell (
      .clk(clk), .rst(rst), .push(push), .sel(sel[i]),
      .din(push_data), .cmp(cmp_value), .chg(chg_value),
      .en(chg_en), .q(word_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pop_q <= FILL;
    else if (push) pop_q <= word_q[slot];
  end

  assign pop_data = pop_q;

  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == 1);
  // R3
  pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !push |=> $stable(pop_data));
  // R1
  rst_fill_chk: assert property (@(posedge clk)
    rst |=> (pop_data == FILL));
endmodule

// File: tb/subst_fifo_test.sv
`timescale 1ns/1ps
module subst_fifo_test;
  localparam int W = 8;
  localparam int D = 16;
  localparam logic [W-1:0] FILL = 8'hA5;

  logic clk = 1'b0;
  logic rst, push, chg_en;
  logic [W-1:0] push_data, cmp_value, chg_value, pop_data;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model [D];
  int mptr;

  always #2 clk = ~clk;

  subst_fifo #(.WIDTH(W), .DEPTH(D), .FILL(FILL)) uut (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .cmp_value(cmp_value), .chg_value(chg_value), .chg_en(chg_en),
    .pop_data(pop_data)
  );

  function automatic logic [W-1:0] repl(logic [W-1:0] v, logic [W-1:0] c,
                                        logic [W-1:0] h, logic e);
    return (e && v == c) ? h : v;
  endfunction

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_push(logic [W-1:0] d, logic [W-1:0] c, logic [W-1:0] h,
                         logic e, string tag);
    logic [W-1:0] exp;
    exp = model[mptr];
    for (int j = 0; j < D; j++)
      if (j != mptr) model[j] = repl(model[j], c, h, e);
    model[mptr] = d;
    mptr = (mptr == D - 1) ? 0 : mptr + 1;
    push = 1'b1; push_data = d; cmp_value = c; chg_value = h; chg_en = e;
    @(negedge clk);
    push = 1'b0; chg_en = 1'b0;
    chk(tag, pop_data, exp);
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'h1234_5678));
    rst = 1'b1; push = 1'b0; chg_en = 1'b0;
    push_data = '0; cmp_value = '0; chg_value = '0;
    for (int j = 0; j < D; j++) model[j] = FILL;
    mptr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset output", pop_data, FILL);

    // R1 / R10: first D pops return fill, load 0..D-1
    for (int i = 0; i < D; i++) do_push(W'(i), 8'h00, 8'h00, 1'b0, "R1 fill drain");

    // R7: chained 5->6 then 6->7
    do_push(8'd20, 8'd5, 8'd6, 1'b1, "R7 chain step1");
    do_push(8'd21, 8'd6, 8'd7, 1'b1, "R7 chain step2");
    // R5: cmp equals word being popped (slot 2 holds 2)
    do_push(8'd22, 8'd2, 8'd99, 1'b1, "R5 pop before replace");
    // R6: inserted word equals cmp
    do_push(8'd9, 8'd9, 8'd1, 1'b1, "R6 insert not compared");

    // R3 / R9: idle with enable high, match on stored word
    held = pop_data;
    push_data = 8'hEE; cmp_value = 8'd7; chg_value = 8'h55; chg_en = 1'b1;
    repeat (4) @(negedge clk);
    chg_en = 1'b0;
    chk("R3 R9 idle output stable", pop_data, held);

    // R8 / R9 / R7: drain with enable low, confirm contents
    for (int i = 0; i < D; i++) do_push(8'(100 + i), 8'd7, 8'd0, 1'b0, "R8 R9 R7 drain");

    // R2 / R4 / R10: random mixed traffic with small values to force matches
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] d, c, h;
      logic e;
      d = W'($urandom_range(0, 7));
      c = W'($urandom_range(0, 7));
      h = W'($urandom_range(0, 7));
      e = ($urandom_range(0, 9) < 3);
      if ($urandom_range(0, 7) == 0) @(negedge clk);
      do_push(d, c, h, e, "R2 R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule